// File: doc/BRIEF.md
# Bidirectional I/O Port with Pull-up Control and Pin Interrupts

This block controls an eight-pin general-purpose port reached through a byte-wide register bus. Each pin has an output latch and a direction bit, and the block drives the pad's tri-state enable from them. A pin set to input can have its weak pull-up switched on by one global active-low control bit. Every pin level passes through a two-flop synchronizer before any read or any edge logic uses it.

Two sticky interrupt sources feed one combined interrupt line. Pin 0 acts as an external interrupt input, and an option bit selects whether its rising or its falling edge is the active one. The upper four pins raise a change flag when their synchronized levels differ from a snapshot. That snapshot is refreshed on every read of the data register. Software clears either flag by writing 0 to its bit.

There are two resets. A power-on reset and a warm reset both restore the direction and option registers. The output latches have no reset at all, so they are undefined after power-on and keep their contents through a warm reset.

Top module: `gpio_port`

## Requirements
- R1: Register map: data at 0x06, direction at 0x86, option at 0x81. Address bit 7 selects the bank. The interrupt control register answers at offset 0x0B in either bank (0x0B and 0x8B). Any other address reads 0x00. Read data appears on `rd_data` in the cycle after `rd_en`.
- R2: A direction bit of 1 makes its pin an input and 0 makes it an output. `pin_oe[i]` is high exactly when direction bit i is 0, and `pin_out` always shows the output latch.
- R3: Both resets set the direction and option registers to 0xFF and the interrupt control register to 0x00.
- R4: The output latch has no reset. Its value survives a warm reset.
- R5: `pullup_en[i]` is high only when direction bit i is 1 and option bit 7 is 0.
- R6: A data register read returns the pin levels after a two-flop synchronizer, not the latch. A pin change made just before clock edge k shows up in a read issued at edge k+2 and not in one issued at edge k+1.
- R7: Control bit 1 (external flag) sets on a rising edge of synchronized pin 0 when option bit 6 is 1, and on a falling edge when option bit 6 is 0.
- R8: Control bit 0 (change flag) sets when synchronized pins 7:4 differ from the snapshot taken at the last data read. Changes on pins 3:1 never set it.
- R9: Both flags are sticky. Writing 0 to a flag bit clears it and writing 1 leaves it unchanged. If a set event falls in the same cycle as a clearing write, the set wins.
- R10: `irq` = (control bit 0 AND control bit 3) OR (control bit 1 AND control bit 4). Bits 3 and 4 are plain read/write enables.
- R11: After either reset, pin levels already present when reset is released set neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | Warm reset, asynchronous, active low |
| addr | input | 8 | Register address, bit 7 is the bank |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Output latch toward pads |
| pin_oe | output | 8 | Pad drive enable, high = drive |
| pullup_en | output | 8 | Weak pull-up enable per pad |
| irq | output | 1 | Combined interrupt |

## Verification
A flag-clearing write to the control register can land in the same cycle as a new edge on pin 0 that sets the same flag. The bench changes pin 0 at the falling clock edge, waits one cycle, and then issues the write. Counting the two synchronizer stages, the edge event and the write then meet at the same rising edge. The following read must show the external flag still set and `irq` high, because a set outweighs a clear.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam logic [7:0] ADDR_DATA = 8'h06;
  localparam logic [7:0] ADDR_DIR  = 8'h86;
  localparam logic [7:0] ADDR_OPT  = 8'h81;
  localparam logic [6:0] OFS_CTL   = 7'h0B;

  localparam int unsigned CTL_CHG_FLAG = 0;
  localparam int unsigned CTL_EXT_FLAG = 1;
  localparam int unsigned CTL_CHG_EN   = 3;
  localparam int unsigned CTL_EXT_EN   = 4;

  localparam int unsigned OPT_PU_N     = 7;
  localparam int unsigned OPT_EDGE     = 6;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_OPT,
    SEL_CTL
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [7:0] a);
    reg_sel_e s;
    if (a == ADDR_DATA)          s = SEL_DATA;
    else if (a == ADDR_DIR)      s = SEL_DIR;
    else if (a == ADDR_OPT)      s = SEL_OPT;
    else if (a[6:0] == OFS_CTL)  s = SEL_CTL;
    else                         s = SEL_NONE;
    return s;
  endfunction
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = 1'b1;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] st_q;
  logic [STAGES-1:0][WIDTH-1:0] st_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb st_d = din;
    end else begin : g_many
      always_comb st_d = {st_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign dout = st_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned CHG_LO  = 4,
  parameter int unsigned ARM_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_s,
  input  logic             edge_rise,
  input  logic             snap_take,
  input  logic             flag_wr,
  input  logic [1:0]       flag_wdata,  // [1]=ext, [0]=chg
  output logic             chg_flag_o,
  output logic             ext_flag_o
);
  localparam int unsigned CHG_W = WIDTH - CHG_LO;

  logic [ARM_LEN-1:0] arm_q, arm_d;
  logic               armed;
  logic [CHG_W-1:0]   snap_q, snap_d;
  logic               prev_q, prev_d;
  logic               chg_q, chg_d, ext_q, ext_d;
  logic               ext_evt, chg_evt;
  logic [CHG_W-1:0]   hi_s;

  assign hi_s  = pins_s[WIDTH-1:CHG_LO];
  assign armed = arm_q[ARM_LEN-1];

  always_comb begin
    arm_d   = {arm_q[ARM_LEN-2:0], 1'b1};
    prev_d  = pins_s[0];
    snap_d  = (snap_take || !armed) ? hi_s : snap_q;
    ext_evt = armed && (edge_rise ? (!prev_q && pins_s[0]) : (prev_q && !pins_s[0]));
    chg_evt = armed && (hi_s != snap_q);
    chg_d   = chg_evt || (chg_q && !(flag_wr && !flag_wdata[0]));
    ext_d   = ext_evt || (ext_q && !(flag_wr && !flag_wdata[1]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= '0;
      snap_q <= '0;
      prev_q <= 1'b0;
      chg_q  <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      arm_q  <= arm_d;
      snap_q <= snap_d;
      prev_q <= prev_d;
      chg_q  <= chg_d;
      ext_q  <= ext_d;
    end
  end

  assign chg_flag_o = chg_q;
  assign ext_flag_o = ext_q;

  // R7: the selected edge on synchronized pin 0 sets the external flag
  p_ext_edge_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && edge_rise && !prev_q && pins_s[0]) |=> ext_flag_o);

  // R8: an upper-nibble mismatch against the snapshot sets the change flag
  p_chg_mismatch_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (hi_s != snap_q)) |=> chg_flag_o);

  // R9: flags stay set unless a clearing write arrives
  p_ext_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_flag_o && !(flag_wr && !flag_wdata[1])) |=> ext_flag_o);
  p_chg_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag_o && !(flag_wr && !flag_wdata[0])) |=> chg_flag_o);

  // R11: no flag can rise before detection is armed
  p_quiet_unarmed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !chg_flag_o && !ext_flag_o) |=> (!chg_flag_o && !ext_flag_o));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CHG_LO      = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic [7:0]       addr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pullup_en,
  output logic             irq
);
  localparam int unsigned ARM_LEN = SYNC_STAGES + 1;

  logic             arst_n, rst_s_n;
  reg_sel_e         sel;
  logic [WIDTH-1:0] pins_s;
  logic [WIDTH-1:0] dir_q, dir_d, opt_q, opt_d, data_q, data_d;
  logic             chg_en_q, chg_en_d, ext_en_q, ext_en_d;
  logic             chg_flag, ext_flag;
  logic [WIDTH-1:0] rd_q, rd_d, rd_mux, ctl_view;
  logic             wr_ctl, snap_take;

  assign arst_n = por_n & rst_n;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_s_n)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .din(pin_in), .dout(pins_s)
  );

  assign sel       = decode_addr(addr);
  assign wr_ctl    = wr_en && (sel == SEL_CTL);
  assign snap_take = rd_en && (sel == SEL_DATA);

  gpio_irq_detect #(.WIDTH(WIDTH), .CHG_LO(CHG_LO), .ARM_LEN(ARM_LEN)) u_irq (
    .clk(clk), .rst_n(rst_s_n), .pins_s(pins_s),
    .edge_rise(opt_q[OPT_EDGE]), .snap_take(snap_take),
    .flag_wr(wr_ctl),
    .flag_wdata({wr_data[CTL_EXT_FLAG], wr_data[CTL_CHG_FLAG]}),
    .chg_flag_o(chg_flag), .ext_flag_o(ext_flag)
  );

  always_comb begin
    dir_d    = (wr_en && sel == SEL_DIR)  ? wr_data : dir_q;
    opt_d    = (wr_en && sel == SEL_OPT)  ? wr_data : opt_q;
    data_d   = (wr_en && sel == SEL_DATA) ? wr_data : data_q;
    chg_en_d = wr_ctl ? wr_data[CTL_CHG_EN] : chg_en_q;
    ext_en_d = wr_ctl ? wr_data[CTL_EXT_EN] : ext_en_q;

    ctl_view               = '0;
    ctl_view[CTL_CHG_FLAG] = chg_flag;
    ctl_view[CTL_EXT_FLAG] = ext_flag;
    ctl_view[CTL_CHG_EN]   = chg_en_q;
    ctl_view[CTL_EXT_EN]   = ext_en_q;

    unique case (sel)
      SEL_DATA: rd_mux = pins_s;
      SEL_DIR:  rd_mux = dir_q;
      SEL_OPT:  rd_mux = opt_q;
      SEL_CTL:  rd_mux = ctl_view;
      default:  rd_mux = '0;
    endcase
    rd_d = rd_en ? rd_mux : rd_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      dir_q    <= '1;
      opt_q    <= '1;
      chg_en_q <= 1'b0;
      ext_en_q <= 1'b0;
      rd_q     <= '0;
    end else begin
      dir_q    <= dir_d;
      opt_q    <= opt_d;
      chg_en_q <= chg_en_d;
      ext_en_q <= ext_en_d;
      rd_q     <= rd_d;
    end
  end

  // output latch: deliberately without reset
  always_ff @(posedge clk) begin
    data_q <= data_d;
  end

  assign rd_data   = rd_q;
  assign pin_out   = data_q;
  assign pin_oe    = ~dir_q;
  assign pullup_en = dir_q & {WIDTH{~opt_q[OPT_PU_N]}};
  assign irq       = (chg_flag & chg_en_q) | (ext_flag & ext_en_q);

  // R1: unmapped reads return zero one cycle later
  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_en && sel == SEL_NONE) |=> (rd_data == '0));

  // R2: a direction write drives the pad enables from the next cycle
  p_dir_write_oe_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && sel == SEL_DIR) |=> (pin_oe == ~$past(wr_data)));

  // R5: global pull-up disable forces all pull-ups off
  p_pullup_gated_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    opt_q[OPT_PU_N] |-> (pullup_en == '0));

  // R10: with both enables clear no interrupt leaves the block
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!chg_en_q && !ext_en_q) |-> !irq);
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam logic [7:0] A_DATA = 8'h06;
  localparam logic [7:0] A_DIR  = 8'h86;
  localparam logic [7:0] A_OPT  = 8'h81;
  localparam logic [7:0] A_CTL  = 8'h0B;
  localparam logic [7:0] A_CTLM = 8'h8B;

  logic       clk = 1'b0;
  logic       por_n, rst_n;
  logic [7:0] addr, wr_data, rd_data, pin_in, pin_out, pin_oe, pullup_en;
  logic       wr_en, rd_en, irq;

  int checks = 0;
  int fails  = 0;
  bit rd_pend = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pullup_en(pullup_en), .irq(irq)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rd_pend) begin
      exp_t e;
      rd_pend = 1'b0;
      e = sb_q.pop_front();
      chk(rd_data, e.exp, e.tag);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    sb_q.push_back('{exp: e, tag: tag});
    @(posedge clk);
    rd_pend = 1'b1;
    #1 rd_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; addr = '0; wr_data = '0;
    wr_en = 1'b0; rd_en = 1'b0; pin_in = 8'h00;
    cyc(3);
    por_n = 1'b1; rst_n = 1'b1;
    cyc(6);

    // reset state
    chk(pin_oe, 8'h00, "R2 oe after reset");
    chk(pullup_en, 8'h00, "R5 pull-ups off after reset");
    chk({7'd0, irq}, 8'h00, "R10 irq after reset");
    rd(A_DIR, 8'hFF, "R3 dir reset");
    rd(A_OPT, 8'hFF, "R3 opt reset");
    rd(A_CTL, 8'h00, "R3 ctl reset");
    rd(8'h10, 8'h00, "R1 unmapped read");
    rd(A_DATA, 8'h00, "R6 data read idle pins");

    // direction and latch
    wr(A_DATA, 8'hA5);
    wr(A_DIR, 8'hCF);
    chk(pin_oe, 8'h30, "R2 oe for CF");
    chk(pin_out, 8'hA5, "R2 latch on pin_out");
    rd(A_DIR, 8'hCF, "R1 dir readback");

    // pull-ups
    wr(A_OPT, 8'h7F);
    chk(pullup_en, 8'hCF, "R5 pull-ups on inputs only");

    // change flag on upper nibble
    pin_in = 8'h3C;
    cyc(4);
    rd(A_DATA, 8'h3C, "R6 read returns pins not latch");
    rd(A_CTL, 8'h01, "R8 change flag set");
    wr(A_CTL, 8'h00);
    rd(A_CTL, 8'h00, "R9 change flag cleared");
    pin_in = 8'h32;
    cyc(4);
    rd(A_CTL, 8'h00, "R8 lower bits ignored");

    // external edge, rising
    pin_in = 8'h33;
    cyc(4);
    rd(A_CTL, 8'h02, "R7 rising edge sets ext flag");
    pin_in = 8'h32;
    cyc(4);
    rd(A_CTL, 8'h02, "R9 ext flag sticky");
    wr(A_CTL, 8'h01);
    rd(A_CTL, 8'h00, "R9 write 0 clears, 1 keeps clear");

    // falling edge select
    wr(A_OPT, 8'h3F);
    pin_in = 8'h33;
    cyc(4);
    rd(A_CTL, 8'h00, "R7 rising ignored in falling mode");
    pin_in = 8'h32;
    cyc(4);
    rd(A_CTL, 8'h02, "R7 falling edge sets ext flag");

    // interrupt combine
    wr(A_CTL, 8'h12);
    chk({7'd0, irq}, 8'h01, "R10 ext enabled irq");
    wr(A_CTL, 8'h08);
    rd(A_CTL, 8'h08, "R10 ctl after clear");
    chk({7'd0, irq}, 8'h00, "R10 irq low after clear");
    pin_in = 8'h72;
    cyc(4);
    chk({7'd0, irq}, 8'h01, "R10 change enabled irq");
    rd(A_CTL, 8'h09, "R8 change flag with enable");
    rd(A_DATA, 8'h72, "R6 data read resnaps");
    wr(A_CTL, 8'h08);
    rd(A_CTL, 8'h08, "R9 change flag cleared after resnap");

    // set wins over clear in the same cycle
    pin_in = 8'h73;
    cyc(4);
    wr(A_CTL, 8'h18);
    rd(A_CTL, 8'h18, "R7 no ext set on rise in falling mode");
    @(negedge clk);
    pin_in = 8'h72;
    @(negedge clk);
    wr(A_CTL, 8'h18);
    rd(A_CTL, 8'h1A, "R9 set wins over clearing write");
    chk({7'd0, irq}, 8'h01, "R9 irq after collision");

    // bank mirror of control
    wr(A_CTLM, 8'h00);
    rd(A_CTL, 8'h00, "R1 ctl mirror write");

    // warm reset keeps latch
    wr(A_DIR, 8'h00);
    wr(A_DATA, 8'h5A);
    chk(pin_oe, 8'hFF, "R2 all outputs");
    pin_in = 8'h73;
    cyc(4);
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(7);
    chk(pin_oe, 8'h00, "R3 warm reset dir");
    chk(pin_out, 8'h5A, "R4 latch kept over warm reset");
    chk(pullup_en, 8'h00, "R3 warm reset opt");
    rd(A_DIR, 8'hFF, "R3 dir after warm reset");
    rd(A_OPT, 8'hFF, "R3 opt after warm reset");
    rd(A_CTL, 8'h00, "R11 no flag from held levels");

    // synchronizer latency
    @(negedge clk);
    pin_in = 8'h00;
    rd(A_DATA, 8'h73, "R6 one edge too early");
    rd(A_DATA, 8'h00, "R6 visible after two edges");

    cyc(3);
    if (sb_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule